// File: doc/BRIEF.md
# Power-management event and timer block

This block sits on a narrow I/O bus and provides the fixed power-management event hardware: a 16-bit event status register, a 16-bit event enable register, and a free-running power-management timer that software reads to measure time. A level interrupt output (SCI) is high while any status bit that may raise an interrupt is both set and enabled.

The timer advances by one on each tick. The tick comes either from an input pin or from an internal phase accumulator. The accumulator adds a fixed step every clock cycle and emits a tick on each carry-out, so a system clock that is not a multiple of 3.579545 MHz still gives the correct long-run rate.

Each time the timer's top bit changes, in either direction, timer status bit 0 is set. Status bits are cleared by writing ones to them. Hardware event sources set status bits through a separate set vector.

Each bus access is presented for one cycle with `io_valid_i` high. Its read data and error flag appear on the next cycle.

Top module: `pm_event_timer`

## Requirements
- R1: An access decodes by offset = address − BASE_ADDR (default 0x1F40), computed modulo 2^ADDR_W. Offsets 0..3 are the event block, with status at offsets 0–1 and enable at offsets 2–3. Offset 8 is the timer. Any other offset, inside or outside the 12-byte window, reads 0, flags no error and changes nothing.
- R2: An event-block read of 1, 2 or 4 bytes returns the little-endian bytes starting at the addressed offset, in the low bits of `io_rdata_o`, one cycle after the access. Bytes past offset 3 read as 0.
- R3: In a legal event-block write, each byte lane that lands on offset 2 or 3 is stored into the matching enable byte (offset 2 = bits 7:0), and the other enable bytes keep their values.
- R4: In a legal event-block write, each byte lane that lands on offset 0 or 1 clears every status bit written as 1 (offset 0 = bits 7:0) and leaves the other bits unchanged.
- R5: `sci_o` is 1 exactly when (status & enable & 0x0121) is nonzero. Only bit 0 (timer), bit 5 and bit 8 can raise it.
- R6: The timer counts up by one per tick and wraps modulo 2^TMR_W. A 4-byte read at offset 8 returns its value, zero-extended.
- R7: Whenever the timer's top bit changes state, rising or falling, status bit 0 is set on the same clock edge as the count.
- R8: If a timer top-bit change and a write clearing status bit 0 occur on the same edge, bit 0 ends up set.
- R9: After reset the status register, the enable register, the timer and `sci_o` are all 0.
- R10: An event-block access whose size is not 1, 2 or 4, or a timer access whose size is not 4, returns read data 0, raises `io_err_o` for one cycle and changes no register. A 4-byte write to the timer is ignored and flags no error.
- R11: With USE_EXT_TICK = 0, exactly ACC_STEP ticks occur in every 2^ACC_W consecutive clock cycles.
- R12: Each cycle, every bit set in `hw_evt_set_i` sets the matching status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_tick_i | input | 1 | External timer tick, used when USE_EXT_TICK = 1 |
| hw_evt_set_i | input | 16 | Hardware status-set vector, one bit per status bit |
| io_valid_i | input | 1 | Access strobe, one cycle per access |
| io_addr_i | input | ADDR_W | I/O byte address |
| io_size_i | input | 3 | Access size in bytes |
| io_write_i | input | 1 | 1 = write, 0 = read |
| io_wdata_i | input | 32 | Write data, byte 0 in bits 7:0 |
| io_rdata_o | output | 32 | Read data, valid the cycle after the access |
| io_err_o | output | 1 | One-cycle flag for an illegal access |
| sci_o | output | 1 | Level power-management interrupt |

## Verification
The main instance is built with TMR_W = 10 and an external tick. This lets the bench drive both the rising and the falling top-bit change, the wrap back to zero, and a flip that lands on the same edge as a status clear, all within a few thousand cycles. A second instance uses the internal accumulator with ACC_W = 8 and ACC_STEP = 100. The bench reads that instance's timer twice, exactly 256 cycles apart, and expects a difference of exactly 100 ticks, which shows the fractional rate is exact.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
  localparam logic [15:0] SCI_SRC_MASK = 16'h0121;

  // one bit per byte lane 0..3 that an access of nbytes at offset off covers
  function automatic logic [3:0] lane_sel(input logic [1:0] off, input logic [2:0] nbytes);
    logic [3:0] s;
    for (int l = 0; l < 4; l++)
      s[l] = (l >= int'(off)) && ((l - int'(off)) < int'(nbytes));
    return s;
  endfunction

  function automatic logic [31:0] lane_align(input logic [31:0] d, input logic [1:0] off);
    return d << (8 * int'(off));
  endfunction

  function automatic logic [31:0] lane_extract(input logic [31:0] w, input logic [1:0] off,
                                               input logic [2:0] nbytes);
    logic [31:0] x;
    x = w >> (8 * int'(off));
    case (nbytes)
      3'd1:    return {24'h0, x[7:0]};
      3'd2:    return {16'h0, x[15:0]};
      default: return x;
    endcase
  endfunction

  function automatic logic evt_size_ok(input logic [2:0] nbytes);
    return (nbytes == 3'd1) || (nbytes == 3'd2) || (nbytes == 3'd4);
  endfunction
endpackage

// File: rtl/pmt_tick_gen.sv
module pmt_tick_gen #(
  parameter bit          USE_EXT_TICK = 1'b0,
  parameter int          ACC_W        = 32,
  parameter logic [63:0] ACC_STEP     = 64'd61496115
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  output logic tick_o
);
  generate
    if (USE_EXT_TICK) begin : g_ext
      assign tick_o = ext_tick;
    end else begin : g_acc
      localparam logic [ACC_W-1:0] STEP = ACC_STEP[ACC_W-1:0];
      logic [ACC_W-1:0] acc;
      logic [ACC_W:0]   sum;
      assign sum    = {1'b0, acc} + {1'b0, STEP};
      assign tick_o = sum[ACC_W];
      always_ff @(posedge clk) begin
        if (!rst_n) acc <= '0;
        else        acc <= sum[ACC_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
  parameter int TMR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             flip_o
);
  localparam int MSB = TMR_W - 1;
  logic [TMR_W-1:0] nxt;
  assign nxt    = cnt_o + 1'b1;
  assign flip_o = tick_i && (nxt[MSB] != cnt_o[MSB]);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (tick_i) cnt_o <= nxt;
  end

  // R6: count advances by one per tick, holds otherwise
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/pmt_evt_regs.sv
module pmt_evt_regs
  import pmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  lanes,
  input  logic [31:0] wdata_al,
  input  logic [15:0] set_i,
  output logic [15:0] sts_o,
  output logic [15:0] en_o,
  output logic        sci_o
);
  logic [31:0] wmask;
  logic [15:0] clr_mask;

  always_comb begin
    for (int l = 0; l < 4; l++)
      wmask[8*l +: 8] = {8{wr_en && lanes[l]}};
  end
  assign clr_mask = wdata_al[15:0] & wmask[15:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_o <= '0;
      en_o  <= '0;
    end else begin
      sts_o <= (sts_o & ~clr_mask) | set_i;   // set wins
      en_o  <= (en_o & ~wmask[31:16]) | (wdata_al[31:16] & wmask[31:16]);
    end
  end

  assign sci_o = |(sts_o & en_o & SCI_SRC_MASK);

  // R4: cleared bits are gone the next cycle unless set at the same time
  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr_mask & ~set_i) |=> (sts_o & $past(clr_mask & ~set_i)) == 16'h0);
  // R8 / R12: set requests always land
  a_r12_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    |set_i |=> (sts_o & $past(set_i)) == $past(set_i));
  // R3: enable moves only on a write
  a_r3_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_o));
endmodule

// File: rtl/pm_event_timer.sv
module pm_event_timer
  import pmt_pkg::*;
#(
  parameter int               ADDR_W       = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h1F40,
  parameter int               TMR_W        = 32,
  parameter bit               USE_EXT_TICK = 1'b0,
  parameter int               ACC_W        = 32,
  parameter logic [63:0]      ACC_STEP     = 64'd61496115
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick_i,
  input  logic [15:0]       hw_evt_set_i,
  input  logic              io_valid_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic [2:0]        io_size_i,
  input  logic              io_write_i,
  input  logic [31:0]       io_wdata_i,
  output logic [31:0]       io_rdata_o,
  output logic              io_err_o,
  output logic              sci_o
);
  localparam logic [ADDR_W-1:0] WIN_BYTES = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] TMR_OFF   = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] EVT_BYTES = ADDR_W'(4);

  logic [ADDR_W-1:0] off;
  logic              in_win, is_evt, is_tmr, legal, evt_wr;
  logic [1:0]        boff;
  logic              tick, flip_evt;
  logic [TMR_W-1:0]  tmr_val;
  logic [15:0]       sts, en;
  logic [31:0]       rd_nxt;

  assign off    = io_addr_i - BASE_ADDR;
  assign boff   = off[1:0];
  assign in_win = off < WIN_BYTES;
  assign is_evt = in_win && (off < EVT_BYTES);
  assign is_tmr = off == TMR_OFF;
  assign legal  = is_evt ? evt_size_ok(io_size_i) : (is_tmr ? (io_size_i == 3'd4) : 1'b1);
  assign evt_wr = io_valid_i && io_write_i && is_evt && legal;

  pmt_tick_gen #(.USE_EXT_TICK(USE_EXT_TICK), .ACC_W(ACC_W), .ACC_STEP(ACC_STEP)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_tick(tmr_tick_i), .tick_o(tick));

  pmt_counter #(.TMR_W(TMR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_o(tmr_val), .flip_o(flip_evt));

  pmt_evt_regs u_evt (
    .clk(clk), .rst_n(rst_n), .wr_en(evt_wr),
    .lanes(lane_sel(boff, io_size_i)),
    .wdata_al(lane_align(io_wdata_i, boff)),
    .set_i(hw_evt_set_i | {15'h0, flip_evt}),
    .sts_o(sts), .en_o(en), .sci_o(sci_o));

  always_comb begin
    rd_nxt = '0;
    if (!io_write_i && legal) begin
      if (is_evt)      rd_nxt = lane_extract({en, sts}, boff, io_size_i);
      else if (is_tmr) rd_nxt = 32'(tmr_val);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_rdata_o <= '0;
      io_err_o   <= 1'b0;
    end else begin
      io_err_o <= io_valid_i && !legal;
      if (io_valid_i) io_rdata_o <= rd_nxt;
    end
  end

  // R7: a top-bit change of the counter shows up in status bit 0
  a_r7_flip_sets_sts: assert property (@(posedge clk) disable iff (!rst_n)
    flip_evt |=> sts[0]);
  // R10: an error response carries no data
  a_r10_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    io_err_o |-> io_rdata_o == 32'h0);
  // R5: SCI can only rise after a write, a timer flip or a hardware set
  a_r5_sci_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci_o) |-> $past((io_valid_i && io_write_i) || flip_evt || (|hw_evt_set_i)));
  // R10: an illegal access leaves the enable register alone
  a_r10_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid_i && !legal && !evt_wr) |=> $stable(en));
endmodule

// File: tb/tb_pm_event_timer.sv
module tb_pm_event_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] hw_set = '0;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic [2:0]  io_size = '0;
  logic        io_write = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata, rdata2;
  logic        io_err, err2, sci, sci2;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd, rd2;
  logic        er;
  int          model_cnt = 0;

  localparam int TW = 10;

  always #2 clk = ~clk;   // 250 MHz

  pm_event_timer #(.TMR_W(TW), .USE_EXT_TICK(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .tmr_tick_i(tick), .hw_evt_set_i(hw_set),
    .io_valid_i(io_valid), .io_addr_i(io_addr), .io_size_i(io_size),
    .io_write_i(io_write), .io_wdata_i(io_wdata),
    .io_rdata_o(io_rdata), .io_err_o(io_err), .sci_o(sci));

  pm_event_timer #(.TMR_W(16), .USE_EXT_TICK(1'b0), .ACC_W(8), .ACC_STEP(64'd100)) dut2 (
    .clk(clk), .rst_n(rst_n), .tmr_tick_i(tick), .hw_evt_set_i(hw_set),
    .io_valid_i(io_valid), .io_addr_i(io_addr), .io_size_i(io_size),
    .io_write_i(io_write), .io_wdata_i(io_wdata),
    .io_rdata_o(rdata2), .io_err_o(err2), .sci_o(sci2));

  function automatic int tmodel();
    return model_cnt % (1 << TW);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic io(input logic [15:0] a, input logic [2:0] s, input logic w, input logic [31:0] d);
    @(negedge clk);
    io_valid = 1'b1; io_addr = a; io_size = s; io_write = w; io_wdata = d;
    @(posedge clk); #1;
    rd = io_rdata; er = io_err; rd2 = rdata2;
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk); tick = 1'b0;
      model_cnt += n;
    end
  endtask

  task automatic hw_pulse(input logic [15:0] m);
    @(negedge clk); hw_set = m;
    @(posedge clk); #1; hw_set = '0;
  endtask

  task automatic t_reset();
    io(16'h1F40, 3'd4, 1'b0, 0); chk("R9 status/enable after reset", rd, 32'h0);
    chk("R9 no error", {31'h0, er}, 32'h0);
    io(16'h1F48, 3'd4, 1'b0, 0); chk("R9 timer after reset", rd, 32'h0);
    chk("R9 sci after reset", {31'h0, sci}, 32'h0);
  endtask

  task automatic t_enable_rw();
    io(16'h1F42, 3'd2, 1'b1, 32'h0000_A5C3);
    io(16'h1F40, 3'd4, 1'b0, 0); chk("R3 enable 2-byte write", rd, 32'hA5C3_0000);
    io(16'h1F43, 3'd1, 1'b0, 0); chk("R2 single byte read offset 3", rd, 32'h0000_00A5);
    io(16'h1F42, 3'd4, 1'b0, 0); chk("R2 bytes past offset 3 read 0", rd, 32'h0000_A5C3);
    io(16'h1F43, 3'd1, 1'b1, 32'h0);
    io(16'h1F42, 3'd2, 1'b0, 0); chk("R3 one byte lane only", rd, 32'h0000_00C3);
    io(16'h1F42, 3'd2, 1'b1, 32'h0);
  endtask

  task automatic t_hw_events();
    io(16'h1F42, 3'd2, 1'b1, 32'hFFFF);
    hw_pulse(16'h8002);
    chk("R5 unmasked bits give no sci", {31'h0, sci}, 32'h0);
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R12 hw set reaches status", rd, 32'h0000_8002);
    hw_pulse(16'h0020);
    chk("R5 bit5 raises sci", {31'h0, sci}, 32'h1);
    io(16'h1F40, 3'd1, 1'b1, 32'h20);
    chk("R4 clear bit5 drops sci", {31'h0, sci}, 32'h0);
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R4 other status bits kept", rd, 32'h0000_8002);
    hw_pulse(16'h0100);
    chk("R5 bit8 raises sci", {31'h0, sci}, 32'h1);
    io(16'h1F41, 3'd1, 1'b1, 32'h01);
    chk("R4 clear via offset 1", {31'h0, sci}, 32'h0);
    io(16'h1F40, 3'd2, 1'b1, 32'hFFFF);
    io(16'h1F40, 3'd4, 1'b0, 0); chk("R4 full clear", rd, 32'hFFFF_0000);
    io(16'h1F42, 3'd2, 1'b1, 32'h0);
  endtask

  task automatic t_timer_flip();
    ticks(511);
    io(16'h1F48, 3'd4, 1'b0, 0); chk("R6 timer counts ticks", rd, 32'(tmodel()));
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R7 no flip yet", rd, 32'h0);
    ticks(1);
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R7 rising top bit sets status0", rd, 32'h1);
    chk("R5 disabled timer status gives no sci", {31'h0, sci}, 32'h0);
    io(16'h1F42, 3'd2, 1'b1, 32'h1);
    chk("R5 enabling timer bit raises sci", {31'h0, sci}, 32'h1);
    io(16'h1F40, 3'd4, 1'b1, 32'h0001_0001);
    chk("R4 4-byte write clears status0", {31'h0, sci}, 32'h0);
    io(16'h1F40, 3'd4, 1'b0, 0); chk("R3 4-byte write stores enable", rd, 32'h0001_0000);
  endtask

  task automatic t_wrap();
    ticks(512);
    io(16'h1F48, 3'd4, 1'b0, 0); chk("R6 timer wraps to 0", rd, 32'h0);
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R7 falling top bit sets status0", rd, 32'h1);
    chk("R5 sci after falling flip", {31'h0, sci}, 32'h1);
  endtask

  task automatic t_set_wins();
    io(16'h1F40, 3'd2, 1'b1, 32'h1);
    ticks(511);
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R7 no flip below top bit", rd, 32'h0);
    @(negedge clk);
    tick = 1'b1; io_valid = 1'b1; io_addr = 16'h1F40; io_size = 3'd2; io_write = 1'b1; io_wdata = 32'h1;
    @(posedge clk); #1;
    tick = 1'b0; io_valid = 1'b0; io_write = 1'b0; model_cnt += 1;
    io(16'h1F40, 3'd2, 1'b0, 0); chk("R8 flip beats same-edge clear", rd, 32'h1);
    io(16'h1F40, 3'd2, 1'b1, 32'h1);
    chk("R8 later clear works", {31'h0, sci}, 32'h0);
  endtask

  task automatic t_errors();
    io(16'h1F48, 3'd2, 1'b0, 0);
    chk("R10 short timer read flags error", {31'h0, er}, 32'h1);
    chk("R10 short timer read data 0", rd, 32'h0);
    @(posedge clk); #1; chk("R10 error lasts one cycle", {31'h0, io_err}, 32'h0);
    io(16'h1F42, 3'd3, 1'b1, 32'hFFFF);
    chk("R10 size-3 event write flags error", {31'h0, er}, 32'h1);
    io(16'h1F40, 3'd4, 1'b0, 0); chk("R10 size-3 write ignored", rd, 32'h0001_0000);
    io(16'h1F48, 3'd4, 1'b1, 32'hDEAD);
    chk("R10 timer write no error", {31'h0, er}, 32'h0);
    io(16'h1F48, 3'd4, 1'b0, 0); chk("R10 timer write ignored", rd, 32'(tmodel()));
    io(16'h1F44, 3'd4, 1'b0, 0); chk("R1 control offset reads 0", rd, 32'h0);
    chk("R1 control offset no error", {31'h0, er}, 32'h0);
    io(16'h1F3E, 3'd4, 1'b1, 32'hFFFF_FFFF);
    io(16'h1F3E, 3'd4, 1'b0, 0); chk("R1 below base reads 0", rd, 32'h0);
    io(16'h1F40, 3'd4, 1'b0, 0); chk("R1 out-of-window write no effect", rd, 32'h0001_0000);
  endtask

  task automatic t_accum();
    logic [15:0] a;
    io(16'h1F48, 3'd4, 1'b0, 0); a = rd2[15:0];
    repeat (255) @(posedge clk);
    io(16'h1F48, 3'd4, 1'b0, 0);
    chk("R11 100 ticks per 256 cycles", 32'(rd2[15:0] - a), 32'd100);
    io(16'h1F48, 3'd4, 1'b0, 0); a = rd2[15:0];
    repeat (511) @(posedge clk);
    io(16'h1F48, 3'd4, 1'b0, 0);
    chk("R11 200 ticks per 512 cycles", 32'(rd2[15:0] - a), 32'd200);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_enable_rw();
    t_hw_events();
    t_timer_flip();
    t_wrap();
    t_set_wins();
    t_errors();
    t_accum();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule